// File: doc/BRIEF.md
# Selectable-Ratio Management Clock Divider

This block derives the serial management clock for an Ethernet PHY management port from the register-interface clock. The clock runs at a fraction of the input frequency, and a 4-bit range code picks that fraction. The aim is to keep the management clock between roughly 1 and 2.5 MHz for whatever input frequency the chip runs at. When the top code bit is clear, the code picks one of six wide ratios. Each of these suits one input band:

| Code | Input band |
|------|------------|
| 2 | 20–35 MHz |
| 3 | 35–60 MHz |
| 0 | 60–100 MHz |
| 1 | 100–150 MHz |
| 4 | 150–250 MHz |
| 5 | 250–300 MHz |

When the top bit is set and fast mode is built in, the low three bits pick one of eight short even ratios.

Besides the divided clock, the block gives a one-cycle strobe in the cycle where the management clock has just gone high, and another in the cycle where it has just gone low. A separate serial shifter can use these strobes to launch and sample data without looking for edges itself. A range change takes effect only at the end of a whole output period, so a code change never produces a shortened pulse. Pulling enable low parks the output low at once and restarts the count.

Top module: `mdc_clk_gen`

## Requirements
- R1: With rangeCode[3] = 0, the codes 0, 1, 2, 3, 4 and 5 give ratios of 42, 62, 16, 26, 102 and 122 input clocks per output period.
- R2: With rangeCode[3] = 1 and FAST_EN = 1, the output period is 4 + 2·rangeCode[2:0] input clocks (4 up to 18).
- R3: The reserved codes 6 and 7 (top bit clear) give the largest ratio, 122.
- R4: With FAST_EN = 0, every code with rangeCode[3] = 1 gives a ratio of 122.
- R5: The output has a 50% duty cycle: it is high for half the ratio and low for half the ratio, in input clocks.
- R6: The block samples rangeCode only at the end of a full output period (the falling edge of mdc), or while it is disabled. A change in the middle of a period does not alter that period's high or low time.
- R7: While en is low, mdc is low from the next cycle on and no strobes are produced. When en goes high, mdc first rises half a ratio later.
- R8: mdcRise is high for exactly the one cycle in which mdc has just become 1. mdcFall is high for exactly the one cycle in which mdc has just become 0. The two are never high together.
- R9: A synchronous reset (rst = 1) drives mdc, mdcRise and mdcFall low on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-interface clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables clock generation |
| rangeCode | input | 4 | Ratio select: top bit picks fast mode, low bits pick the entry |
| mdc | output | 1 | Divided management clock |
| mdcRise | output | 1 | One-cycle strobe in the cycle where mdc has just risen |
| mdcFall | output | 1 | One-cycle strobe in the cycle where mdc has just fallen |

## Verification
The embedded assertions check several properties on every cycle:
- the latched ratio never moves except at a period boundary or while the block is disabled;
- the count stays below the latched half ratio;
- disabling forces mdc and the count to zero;
- the edge strobes are exclusive and line up with the real transitions of mdc.

The actual ratio for each code is visible only in the bench scenarios, which measure the high and low runs for every code in both modes and in a build without fast mode. The same applies to the delay to the first rise after enable, and to the way a mid-period code change lands one whole period later.

// File: rtl/mdcdiv_pkg.sv
package mdcdiv_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic clear;  // hold counter and output idle
    logic wrap;   // half period complete: reload and toggle
  } mdcStrobe_t;

  // Largest half ratio, used for reserved codes
  localparam int unsigned MAX_HALF = 61;

  // Half of the division ratio selected by a range code
  function automatic int unsigned halfRatio(input logic [3:0] code, input logic fastEn);
    int unsigned h;
    if (code[3]) begin
      if (fastEn) h = 2 + int'(code[2:0]);
      else        h = MAX_HALF;
    end else begin
      case (code[2:0])
        3'd0:    h = 21;
        3'd1:    h = 31;
        3'd2:    h = 8;
        3'd3:    h = 13;
        3'd4:    h = 51;
        3'd5:    h = 61;
        default: h = MAX_HALF;
      endcase
    end
    return h;
  endfunction

endpackage

// File: rtl/mdcdiv_ctrl.sv
module mdcdiv_ctrl
  import mdcdiv_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter bit FAST_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [3:0]       rangeCode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             mdc,
  output mdcStrobe_t       strobe
);

  logic [CNT_W-1:0] halfReg;
  logic [CNT_W-1:0] nextHalf;
  logic             wrap;
  logic             capture;

  assign nextHalf = CNT_W'(halfRatio(rangeCode, FAST_EN));
  assign wrap     = en && (cnt == halfReg - 1'b1);
  // Latch a new ratio only at the end of a full period or while idle
  assign capture  = !en || (wrap && mdc);

  always_ff @(posedge clk) begin
    if (rst)          halfReg <= CNT_W'(MAX_HALF);
    else if (capture) halfReg <= nextHalf;
  end

  assign strobe.clear = !en;
  assign strobe.wrap  = wrap;

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !(wrap && mdc)) |=> $stable(halfReg));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < halfReg));

endmodule

// File: rtl/mdcdiv_dpath.sv
module mdcdiv_dpath
  import mdcdiv_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  mdcStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             mdc,
  output logic             mdcRise,
  output logic             mdcFall
);

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      cnt     <= '0;
      mdc     <= 1'b0;
      mdcRise <= 1'b0;
      mdcFall <= 1'b0;
    end else begin
      if (strobe.wrap) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
      mdcRise <= strobe.wrap & ~mdc;
      mdcFall <= strobe.wrap & mdc;
    end
  end

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (!mdc && !mdcRise && !mdcFall && cnt == '0));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mdcRise, mdcFall}));

  // R8
  rise_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> mdcRise);

  // R8
  fall_align_chk: assert property (@(posedge clk) disable iff (rst)
    mdcFall |-> (!mdc && $past(mdc)));

endmodule

// File: rtl/mdc_clk_gen.sv
module mdc_clk_gen
  import mdcdiv_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter bit FAST_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [3:0] rangeCode,
  output logic       mdc,
  output logic       mdcRise,
  output logic       mdcFall
);

  mdcStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;

  mdcdiv_ctrl #(.CNT_W(CNT_W), .FAST_EN(FAST_EN)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .rangeCode(rangeCode),
    .cnt(cnt), .mdc(mdc), .strobe(strobe)
  );

  mdcdiv_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .cnt(cnt),
    .mdc(mdc), .mdcRise(mdcRise), .mdcFall(mdcFall)
  );

endmodule

// File: tb/mdc_clk_gen_bench.sv
module mdc_clk_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] rangeCode = 4'd0;
  logic       mdcA, riseA, fallA;
  logic       mdcB, riseB, fallB;

  int errors = 0;
  int checks = 0;
  bit useB = 1'b0;
  bit pulseBad;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mdc_clk_gen u_mdc_clk_gen (
    .clk(clk), .rst(rst), .en(en), .rangeCode(rangeCode),
    .mdc(mdcA), .mdcRise(riseA), .mdcFall(fallA)
  );

  mdc_clk_gen #(.FAST_EN(1'b0)) u_mdc_clk_gen_nofast (
    .clk(clk), .rst(rst), .en(en), .rangeCode(rangeCode),
    .mdc(mdcB), .mdcRise(riseB), .mdcFall(fallB)
  );

  function automatic logic selMdc();  return useB ? mdcB  : mdcA;  endfunction
  function automatic logic selRise(); return useB ? riseB : riseA; endfunction
  function automatic logic selFall(); return useB ? fallB : fallA; endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count consecutive negedge samples at level lvl, checking strobes on the way
  task automatic runPhase(input logic lvl, output int len);
    logic prev;
    len = 0;
    while (selMdc() == lvl && len < 400) begin
      prev = selMdc();
      len++;
      @(negedge clk);
      if (selRise() !== (selMdc() && !prev)) pulseBad = 1'b1;
      if (selFall() !== (!selMdc() && prev)) pulseBad = 1'b1;
    end
  endtask

  task automatic startCode(input logic [3:0] c);
    @(negedge clk);
    en = 1'b0;
    rangeCode = c;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  // R1 R2 R3 R4 R5 R7 R8: measure the first low run, a high run and the next low run
  task automatic measureCode(input logic [3:0] c, input int ratio, input string req);
    int lenLo0, lenHi, lenLo;
    pulseBad = 1'b0;
    startCode(c);
    runPhase(1'b0, lenLo0);
    runPhase(1'b1, lenHi);
    runPhase(1'b0, lenLo);
    check({req, " R7 first rise"}, lenLo0, ratio / 2);
    check({req, " R5 high"}, lenHi, ratio / 2);
    check({req, " R5 low"}, lenLo, ratio / 2);
    check({req, " R8 strobes"}, int'(pulseBad), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R9 mdc after reset", int'(mdcA), 0);
    check("R9 strobes after reset", int'(riseA | fallA), 0);
  endtask

  // R6: code change during a low phase lands one full period later
  task automatic testCodeChange();
    int l0, h0, lRest, hOld, lNew;
    startCode(4'd0);
    runPhase(1'b0, l0);
    runPhase(1'b1, h0);
    repeat (5) @(negedge clk);
    rangeCode = 4'd2;
    runPhase(1'b0, lRest);
    runPhase(1'b1, hOld);
    runPhase(1'b0, lNew);
    check("R6 old low finishes", lRest + 5, 21);
    check("R6 old high kept", hOld, 21);
    check("R6 new low", lNew, 8);
  endtask

  // R7: dropping en mid-high parks output low with no strobes
  task automatic testDisable();
    int l0, bad;
    startCode(4'd8);
    runPhase(1'b0, l0);
    @(negedge clk);
    en = 1'b0;
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (mdcA || riseA || fallA) bad++;
    end
    check("R7 idle while disabled", bad, 0);
  endtask

  // R9: reset while running
  task automatic testRunReset();
    int l0;
    startCode(4'd9);
    runPhase(1'b0, l0);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid-run reset mdc", int'(mdcA), 0);
    check("R9 mid-run reset strobes", int'(riseA | fallA), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    measureCode(4'd0, 42, "R1 code0");
    measureCode(4'd1, 62, "R1 code1");
    measureCode(4'd2, 16, "R1 code2");
    measureCode(4'd3, 26, "R1 code3");
    measureCode(4'd4, 102, "R1 code4");
    measureCode(4'd5, 122, "R1 code5");
    measureCode(4'd6, 122, "R3 code6");
    measureCode(4'd7, 122, "R3 code7");
    for (int k = 0; k < 8; k++) measureCode(4'(8 + k), 4 + 2 * k, "R2 fast");
    useB = 1'b1;
    measureCode(4'd9, 122, "R4 nofast code9");
    measureCode(4'd15, 122, "R4 nofast code15");
    measureCode(4'd3, 26, "R4 nofast normal code3");
    useB = 1'b0;
    testCodeChange();
    testDisable();
    testRunReset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule